// File: doc/BRIEF.md
# Supply Reset Sequencer

This block turns two digitized supply-monitor flags into the chip's system reset. One flag says the supply has cleared the power-on threshold; the other says it is above the brown-out trip point. While either flag is low, the system reset is held. The reset is raised at once, without waiting for a clock, and is dropped only on a clock edge after a series of settling delays has run out.

After a power-on, the release waits for a fixed power-on delay. After a brown-out, the release waits for a fixed brown-out settling delay and then for a power-up timer. The power-up timer length is chosen by a 3-bit setting. Each return of the supply above the trip point starts this combined delay again from zero. The delays are counted on a free-running low-frequency clock.

The block also keeps two sticky cause flags. Software reads them on a small status port and clears them by writing zeros.

Top module: `supply_reset_seq`

## Requirements
- R1: `sys_rst` is 1 at once, with no clock edge needed, whenever `por_good` or `bor_good` is 0.
- R2: When `por_good` and `bor_good` rise together, `sys_rst` falls on the (POR_CYC+2)-th rising clock edge after the rise. The extra 2 edges are the synchronizer.
- R3: A power-on reset leaves `stat_flags[0]` (power-on cause) at 1 and `stat_flags[1]` (brown-out cause) at 0. Bit 0 can never go from 0 to 1 except through a power-on reset.
- R4: After a brown-out, `sys_rst` falls on the (3+BOR_CYC+T)-th rising edge after `bor_good` returns to 1. T is the power-up timer length in cycles.
- R5: `pwrt_sel` values 0..7 select a power-up timer of 0, 2, 4, 8, 16, 32, 64 or 128 ms, where T = ms × CYC_PER_MS. A value of 0 skips the timer stage.
- R6: A dip of `bor_good` during the brown-out delay or the power-up timer restarts the combined delay. The release then follows the last rise, as in R4.
- R7: A fall of `bor_good` after a power-on reset has completed sets `stat_flags[1]`, whether the system was running or still counting a delay.
- R8: A write with `stat_wr`=1 clears every flag bit whose `stat_wdata` bit is 0 and leaves the bits written as 1 unchanged. A flag stays set until it is cleared this way.
- R9: If `bor_good` is still low when the power-on delay ends, reset stays asserted without setting `stat_flags[1]`. It is then released as in R4 after `bor_good` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency delay clock |
| por_good | input | 1 | Supply above power-on threshold; low acts as asynchronous block reset |
| bor_good | input | 1 | Supply above brown-out trip point |
| pwrt_sel | input | 3 | Power-up timer length select |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Status write data; a 0 bit clears the matching flag |
| stat_flags | output | 2 | Sticky cause flags: bit 0 power-on, bit 1 brown-out |
| sys_rst | output | 1 | System reset, active high |

## Verification
The checker assumes the following about the inputs:
- `por_good` acts as the block's asynchronous reset, so every property is disabled while it is low.
- `bor_good` is a level from a comparator, and any change in it is a real supply event.
- `pwrt_sel` holds steady while the brown-out delay is counting.

The stimulus changes inputs only at falling clock edges and holds each `bor_good` dip for several cycles, so the synchronizer always sees it. It also sets `pwrt_sel` before each brown-out scenario begins.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_LOW  = 3'd1,
        ST_BDLY = 3'd2,
        ST_PWRT = 3'd3,
        ST_RUN  = 3'd4
    } srs_state_e;
endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/pwrt_decode.sv
module pwrt_decode #(
    parameter int CYC_PER_MS = 16,
    parameter int CNT_W      = 12
) (
    input  logic [2:0]       sel,
    output logic [CNT_W-1:0] cycles
);
    // setting 0 means no timer; otherwise 2^sel milliseconds
    always_comb begin
        if (sel == 3'd0) begin
            cycles = '0;
        end else begin
            cycles = CNT_W'(CYC_PER_MS) << sel;
        end
    end
endmodule

// File: rtl/status_regs.sv
module status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_bor,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    output logic [1:0] flags
);
    logic [1:0] flags_d;
    logic [1:0] flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d = flags_d & wdata;
        end
        if (set_bor) begin
            flags_d[1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= 2'b01;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int CYC_PER_MS = 16,
    parameter int POR_CYC    = 40,
    parameter int BOR_CYC    = 24
) (
    input  logic       clk,
    input  logic       por_good,
    input  logic       bor_good,
    input  logic [2:0] pwrt_sel,
    input  logic       stat_wr,
    input  logic [1:0] stat_wdata,
    output logic [1:0] stat_flags,
    output logic       sys_rst
);
    localparam int PWRT_MAX = 128 * CYC_PER_MS;
    localparam int MAX_A    = (POR_CYC > BOR_CYC) ? POR_CYC : BOR_CYC;
    localparam int MAX_ALL  = (MAX_A > PWRT_MAX) ? MAX_A : PWRT_MAX;
    localparam int CNT_W    = $clog2(MAX_ALL + 1);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] BOR_LAST = CNT_W'(BOR_CYC - 1);

    typedef struct packed {
        srs_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             rst;
    } seq_t;

    seq_t             s_d;
    seq_t             s_q;
    logic [1:0]       sync_q;
    logic             por_s;
    logic             bor_s;
    logic             set_bor;
    logic [CNT_W-1:0] pwrt_cyc;

    supply_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (por_good),
        .d     ({bor_good, 1'b1}),
        .q     (sync_q)
    );
    assign por_s = sync_q[0];
    assign bor_s = sync_q[1];

    pwrt_decode #(.CYC_PER_MS(CYC_PER_MS), .CNT_W(CNT_W)) u_dec (
        .sel    (pwrt_sel),
        .cycles (pwrt_cyc)
    );

    status_regs u_stat (
        .clk     (clk),
        .rst_n   (por_good),
        .set_bor (set_bor),
        .wr_en   (stat_wr),
        .wdata   (stat_wdata),
        .flags   (stat_flags)
    );

    always_comb begin
        s_d     = s_q;
        set_bor = 1'b0;
        case (s_q.st)
            ST_POR: begin
                if (por_s) begin
                    if (s_q.cnt == POR_LAST) begin
                        s_d.cnt = '0;
                        s_d.st  = bor_s ? ST_RUN : ST_LOW;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_LOW: begin
                s_d.cnt = '0;
                if (bor_s) begin
                    s_d.st = ST_BDLY;
                end
            end
            ST_BDLY: begin
                if (!bor_s) begin
                    s_d.st  = ST_LOW;
                    s_d.cnt = '0;
                    set_bor = 1'b1;
                end else if (s_q.cnt == BOR_LAST) begin
                    s_d.cnt = '0;
                    if (pwrt_cyc == '0) begin
                        s_d.st = ST_RUN;
                    end else begin
                        s_d.st  = ST_PWRT;
                        s_d.lim = pwrt_cyc;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PWRT: begin
                if (!bor_s) begin
                    s_d.st  = ST_LOW;
                    s_d.cnt = '0;
                    set_bor = 1'b1;
                end else if (s_q.cnt == s_q.lim - 1'b1) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_RUN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!bor_s) begin
                    s_d.st  = ST_LOW;
                    set_bor = 1'b1;
                end
            end
            default: begin
                s_d.st  = ST_LOW;
                s_d.cnt = '0;
            end
        endcase
        s_d.rst = (s_d.st != ST_RUN);
    end

    always_ff @(posedge clk or negedge por_good) begin
        if (!por_good) begin
            s_q.st  <= ST_POR;
            s_q.cnt <= '0;
            s_q.lim <= '0;
            s_q.rst <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // raised asynchronously by either supply flag, released on a clock edge
    assign sys_rst = s_q.rst | ~por_good | ~bor_good;
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
    parameter int POR_CYC = 40,
    parameter int BOR_CYC = 24
) (
    input logic       clk,
    input logic       por_good,
    input logic       bor_good,
    input logic       stat_wr,
    input logic [1:0] stat_wdata,
    input logic [1:0] stat_flags,
    input logic       sys_rst
);
    localparam int MIN_DLY = (POR_CYC < BOR_CYC) ? POR_CYC : BOR_CYC;

    logic [15:0] good_run;

    always_ff @(posedge clk or negedge por_good) begin
        if (!por_good) begin
            good_run <= '0;
        end else if (!bor_good) begin
            good_run <= '0;
        end else if (good_run != 16'hFFFF) begin
            good_run <= good_run + 16'd1;
        end
    end

    p_rst_on_low_r1: assert property (@(posedge clk) disable iff (!por_good)
        !bor_good |-> sys_rst);

    p_por_flag_hold_r3: assert property (@(posedge clk) disable iff (!por_good)
        !stat_flags[0] |=> !stat_flags[0]);

    p_min_delay_r4: assert property (@(posedge clk) disable iff (!por_good)
        $fell(sys_rst) |-> (good_run >= 16'(MIN_DLY)));

    p_bor_sticky_r8: assert property (@(posedge clk) disable iff (!por_good)
        (stat_flags[1] && !(stat_wr && !stat_wdata[1])) |=> stat_flags[1]);

    p_clear_por_r8: assert property (@(posedge clk) disable iff (!por_good)
        (stat_wr && !stat_wdata[0]) |=> !stat_flags[0]);
endmodule

bind supply_reset_seq srs_checker #(.POR_CYC(POR_CYC), .BOR_CYC(BOR_CYC)) u_chk (
    .clk        (clk),
    .por_good   (por_good),
    .bor_good   (bor_good),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_flags (stat_flags),
    .sys_rst    (sys_rst)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
    localparam int CPMS = 16;
    localparam int PORC = 40;
    localparam int BORC = 24;

    logic       clk = 1'b0;
    logic       por_good = 1'b0;
    logic       bor_good = 1'b0;
    logic [2:0] pwrt_sel = 3'd0;
    logic       stat_wr = 1'b0;
    logic [1:0] stat_wdata = 2'b11;
    logic [1:0] stat_flags;
    logic       sys_rst;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    supply_reset_seq #(.CYC_PER_MS(CPMS), .POR_CYC(PORC), .BOR_CYC(BORC)) u_dut (
        .clk        (clk),
        .por_good   (por_good),
        .bor_good   (bor_good),
        .pwrt_sel   (pwrt_sel),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .stat_flags (stat_flags),
        .sys_rst    (sys_rst)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: got=%0d exp=<100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int pwrt_len(input logic [2:0] s);
        if (s == 3'd0) return 0;
        return (1 << s) * CPMS;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        total = total + 1;
        if (got != exp) begin
            bad = bad + 1;
            $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (sys_rst === 1'b1 && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic write_stat(input logic [1:0] d);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0;
        stat_wdata = 2'b11;
    endtask

    task automatic t_power_on();
        int n;
        wait_cyc(4);
        check("R1 reset held while supply low", int'(sys_rst), 1);
        check("R3 flags during power-on", int'(stat_flags), 1);
        por_good = 1'b1;
        bor_good = 1'b1;
        measure(n);
        check("R2 power-on release edges", n, PORC + 2);
        check("R3 flags after power-on", int'(stat_flags), 1);
    endtask

    task automatic t_brownout(input logic [2:0] sel);
        int n;
        pwrt_sel = sel;
        @(negedge clk);
        bor_good = 1'b0;
        #1;
        check("R1 immediate assert on brown-out", int'(sys_rst), 1);
        wait_cyc(5);
        bor_good = 1'b1;
        measure(n);
        check("R4 R5 brown-out release edges", n, 3 + BORC + pwrt_len(sel));
        check("R7 brown-out flag set", int'(stat_flags[1]), 1);
        write_stat(2'b01);
        check("R8 clear brown-out flag", int'(stat_flags), 1);
    endtask

    task automatic t_dip_restart();
        int n;
        pwrt_sel = 3'd2;
        @(negedge clk);
        bor_good = 1'b0;
        wait_cyc(5);
        bor_good = 1'b1;
        wait_cyc(3 + BORC + 10);
        check("R6 still in reset during timer", int'(sys_rst), 1);
        bor_good = 1'b0;
        wait_cyc(4);
        bor_good = 1'b1;
        measure(n);
        check("R6 release counted from last rise", n, 3 + BORC + pwrt_len(3'd2));
        check("R7 flag after dip in timer", int'(stat_flags), 3);
    endtask

    task automatic t_writes();
        write_stat(2'b11);
        check("R8 write of ones leaves flags", int'(stat_flags), 3);
        write_stat(2'b10);
        check("R8 clear only power-on flag", int'(stat_flags), 2);
        write_stat(2'b00);
        check("R8 clear all flags", int'(stat_flags), 0);
        wait_cyc(3);
        check("R3 power-on flag stays clear", int'(stat_flags[0]), 0);
    endtask

    task automatic t_por_bor_low();
        int n;
        pwrt_sel = 3'd1;
        @(negedge clk);
        por_good = 1'b0;
        bor_good = 1'b0;
        wait_cyc(4);
        por_good = 1'b1;
        wait_cyc(PORC + 10);
        check("R9 reset held with brown-out low", int'(sys_rst), 1);
        check("R9 no brown-out flag", int'(stat_flags), 1);
        bor_good = 1'b1;
        measure(n);
        check("R9 release after late supply", n, 3 + BORC + pwrt_len(3'd1));
        check("R9 flags after release", int'(stat_flags), 1);
    endtask

    initial begin
        t_power_on();
        t_brownout(3'd0);
        t_brownout(3'd1);
        t_brownout(3'd3);
        t_dip_restart();
        t_writes();
        t_por_bor_low();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule